// File: doc/BRIEF.md
# Buffered Single-Tone Phase Generator

This block is the phase-generation core of a direct digital synthesiser producing one tone. A host loads a 64-bit profile word (amplitude scale, phase offset and frequency tuning word) into a holding buffer. Nothing changes at the output until an update strobe is seen on the SYNC clock. The strobe first moves the buffer into a staging slot, and one SYNC cycle later into the active registers that drive the output.

The core runs on the SYNC clock, which stands for four cycles of the fast sample clock. In each SYNC cycle it presents four consecutive sample phases, lane 0 first. A 32-bit unsigned accumulator advances by four tuning words per SYNC cycle and wraps modulo 2^32. Each lane's 16-bit phase is the top half of its accumulator value plus the active phase offset.

A configuration bit selects accumulator auto-clear. When it is set, an update zeroes the accumulator at the registration edge. The next SYNC cycle is then a dead cycle: every lane reads phase 0 and the accumulator does not move. After that the new parameters run from an accumulator of zero. Measured against a clear that lines up with the parameter change, this leaves the accumulator short by four times the new tuning word.

Top module: `dds_tone_core`

## Requirements
- R1: While rstN is low and after reset, the accumulator, buffer, staging and active registers are zero and auto-clear is off. All four phase lanes and ampOut read 0 until a transfer loads nonzero data.
- R2: While no update is in progress, the accumulator advances by 4*FTW (unsigned, modulo 2^32) at every SYNC edge. Lane j uses accumulator + j*FTW, for j = 0..3.
- R3: Lane j phase = bits [31:16] of (accumulator + j*FTW), plus the active phase offset, modulo 2^16. phaseOut[16*j+15:16*j] carries lane j.
- R4: Profile word layout: bits [63:48] amplitude scale (shown on ampOut), bits [47:32] phase offset, bits [31:0] tuning word.
- R5: A buffer write (wrEn high at an edge) has no effect on phaseOut or ampOut until an update transfers it.
- R6: Let k be the first edge that samples ioUpdate high. Edge k+1 registers the update and copies the buffer into staging. Edge k+2 loads the active registers, so the new values govern the outputs from the cycle after edge k+2.
- R7: An ioUpdate held high for many cycles causes exactly one transfer. Buffer writes made while it stays high are not transferred.
- R8: With auto-clear on, the accumulator becomes 0 at edge k+1. During the cycle between k+1 and k+2 all lanes read phase 0 and ampOut keeps the old amplitude. The accumulator is still 0 after edge k+2, so lane j then reads (j*FTWnew)[31:16] + POWnew.
- R9: With auto-clear off, an update keeps the phase continuous. The accumulator advances with the old tuning word at edges k+1 and k+2, then with the new one.
- R10: An update after reset with no buffer write loads all-zero parameters.
- R11: cfgWr high at an edge loads cfgAutoClear into the auto-clear bit. With cfgWr low the bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SYNC clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Buffer write strobe |
| wrData | input | 64 | Profile word for the buffer |
| cfgWr | input | 1 | Auto-clear configuration write strobe |
| cfgAutoClear | input | 1 | Auto-clear value written when cfgWr is high |
| ioUpdate | input | 1 | Update strobe; its rising edge requests a transfer |
| phaseOut | output | 64 | Four 16-bit sample phases, lane 0 in the low bits |
| ampOut | output | 16 | Active amplitude scale |

## Verification
The outputs are combinational from the active registers and the accumulator, so each SYNC edge shows its effect in the phases during the following low clock phase. The bench samples at the falling edge that follows each rising edge. A reference model advances at every rising edge and applies the update events at the edges fixed by the timing requirements. Counting from the first edge that sees ioUpdate high, the model clears at the first edge after it (auto-clear), loads the new parameters at the second, and the bench compares every cycle in between. Buffer and configuration writes take effect at the edge that samples them, but the phases show them only through a later transfer.

// File: rtl/dds_tone_pkg.sv
package dds_tone_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic stage;  // copy buffer into staging (registration edge)
    logic clear;  // zero accumulator at registration edge
    logic hold;   // dead cycle: freeze accumulator, phases read zero
    logic load;   // move staging into active registers
  } dds_ctl_t;
endpackage

// File: rtl/dds_tone_ctl.sv
module dds_tone_ctl
  import dds_tone_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  logic     cfgAutoClear,
  input  logic     ioUpdate,
  output dds_ctl_t ctl
);
  logic ioSamp, ioPrev, autoClr, holdQ, loadQ;
  logic risePulse;

  assign risePulse = ioSamp & ~ioPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioSamp  <= 1'b0;
      ioPrev  <= 1'b0;
      autoClr <= 1'b0;
      holdQ   <= 1'b0;
      loadQ   <= 1'b0;
    end else begin
      ioSamp <= ioUpdate;
      ioPrev <= ioSamp;
      if (cfgWr) autoClr <= cfgAutoClear;
      holdQ <= risePulse & autoClr;
      loadQ <= risePulse;
    end
  end

  always_comb begin
    ctl.stage = risePulse;
    ctl.clear = risePulse & autoClr;
    ctl.hold  = holdQ;
    ctl.load  = loadQ;
  end

  // one transfer per strobe
  assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    risePulse |=> !risePulse);
  // dead cycle only occurs together with a pending load
  assert_hold_with_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    holdQ |-> loadQ);
endmodule

// File: rtl/dds_tone_dp.sv
module dds_tone_dp
  import dds_tone_pkg::*;
#(
  parameter int FTW_W = 32,
  parameter int POW_W = 16,
  parameter int ASF_W = 16,
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dds_ctl_t                 ctl,
  input  logic                     wrEn,
  input  logic [ASF_W+POW_W+FTW_W-1:0] wrData,
  output logic [LANES*POW_W-1:0]   phaseOut,
  output logic [ASF_W-1:0]         ampOut
);
  localparam int PW      = ASF_W + POW_W + FTW_W;
  localparam int POW_LSB = FTW_W;
  localparam int ASF_LSB = FTW_W + POW_W;

  logic [PW-1:0]    bufQ, stageQ;
  logic [ASF_W-1:0] asfAct;
  logic [POW_W-1:0] powAct;
  logic [FTW_W-1:0] ftwAct, acc, stepAll;

  assign stepAll = FTW_W'(LANES) * ftwAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ   <= '0;
      stageQ <= '0;
      asfAct <= '0;
      powAct <= '0;
      ftwAct <= '0;
      acc    <= '0;
    end else begin
      if (wrEn)      bufQ   <= wrData;
      if (ctl.stage) stageQ <= bufQ;
      if (ctl.load) begin
        asfAct <= stageQ[ASF_LSB +: ASF_W];
        powAct <= stageQ[POW_LSB +: POW_W];
        ftwAct <= stageQ[0 +: FTW_W];
      end
      if (ctl.clear)     acc <= '0;
      else if (!ctl.hold) acc <= acc + stepAll;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FTW_W-1:0] laneAcc;
    logic [POW_W-1:0] lanePh;
    assign laneAcc = acc + FTW_W'(j) * ftwAct;
    assign lanePh  = laneAcc[FTW_W-1 -: POW_W] + powAct;
    assign phaseOut[j*POW_W +: POW_W] = ctl.hold ? '0 : lanePh;
  end

  assign ampOut = asfAct;

  // dead cycle keeps the accumulator at zero
  assert_hold_zero_acc_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |-> (acc == '0));
  // active registers only change on a load strobe
  assert_active_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(ftwAct) && $stable(powAct) && $stable(asfAct));
  // zero tuning word: accumulator does not move
  assert_zero_ftw_still_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !ctl.load && ftwAct == '0) |=> $stable(acc));
  // during dead cycle every lane is zero
  assert_hold_phase_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |-> (phaseOut == '0));
endmodule

// File: rtl/dds_tone_core.sv
module dds_tone_core
  import dds_tone_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [63:0] wrData,
  input  logic        cfgWr,
  input  logic        cfgAutoClear,
  input  logic        ioUpdate,
  output logic [63:0] phaseOut,
  output logic [15:0] ampOut
);
  dds_ctl_t ctl;

  dds_tone_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAutoClear(cfgAutoClear),
    .ioUpdate(ioUpdate), .ctl(ctl)
  );

  dds_tone_dp #(.FTW_W(32), .POW_W(16), .ASF_W(16), .LANES(4)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(wrEn), .wrData(wrData),
    .phaseOut(phaseOut), .ampOut(ampOut)
  );
endmodule

// File: tb/sim_dds_tone_core.sv
module sim_dds_tone_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        cfgWr = 1'b0;
  logic        cfgAutoClear = 1'b0;
  logic        ioUpdate = 1'b0;
  logic [63:0] phaseOut;
  logic [15:0] ampOut;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit [31:0] mAcc = 0, mFtw = 0;
  bit [15:0] mPow = 0, mAsf = 0;
  bit        mHold = 0;
  bit [63:0] mBuf = 0, mStage = 0;

  dds_tone_core u0 (.*);

  always #10 clk = ~clk;

  function automatic bit [63:0] expPhases();
    bit [63:0] v = '0;
    for (int j = 0; j < 4; j++) begin
      bit [31:0] t = mAcc + 32'(j) * mFtw;
      v[16*j +: 16] = mHold ? 16'h0 : t[31:16] + mPow;
    end
    return v;
  endfunction

  task automatic compare(string tag);
    bit [63:0] e = expPhases();
    checks++;
    if (phaseOut !== e || ampOut !== mAsf) begin
      errors++;
      $display("FAIL %s phase=%h amp=%h expected phase=%h amp=%h", tag, phaseOut, ampOut, e, mAsf);
    end
  endtask

  // ev: 0 normal edge, 1 registration edge, 2 apply edge
  task automatic cyc(int ev, bit clr, string tag);
    @(posedge clk);
    if (ev == 1) begin
      mStage = mBuf;
      if (clr) begin mAcc = 0; mHold = 1; end
      else mAcc = mAcc + 32'd4 * mFtw;
    end else if (ev == 2) begin
      if (mHold) mHold = 0;
      else mAcc = mAcc + 32'd4 * mFtw;
      mAsf = mStage[63:48]; mPow = mStage[47:32]; mFtw = mStage[31:0];
    end else begin
      mAcc = mAcc + 32'd4 * mFtw;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic writeProf(bit [63:0] d, string tag);
    wrEn = 1'b1; wrData = d;
    cyc(0, 0, tag);
    mBuf = d;
    wrEn = 1'b0;
  endtask

  task automatic setCfg(bit we, bit v, string tag);
    cfgWr = we; cfgAutoClear = v;
    cyc(0, 0, tag);
    cfgWr = 1'b0;
  endtask

  // strobe ioUpdate; leaves it high if keepHigh
  task automatic update(bit clr, bit keepHigh, string tag);
    ioUpdate = 1'b1;
    cyc(0, clr, tag);          // edge k samples it
    if (!keepHigh) ioUpdate = 1'b0;
    cyc(1, clr, tag);          // edge k+1 registers
    cyc(2, clr, tag);          // edge k+2 applies
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    run(3, "R1 after reset");
    update(0, 0, "R10 update of empty buffer");
    run(2, "R10 zeros remain");

    writeProf({16'h1234, 16'h0100, 32'h0100_0000}, "R5 write");
    run(3, "R5 no effect before update");
    update(0, 0, "R6 R4 transfer");
    run(6, "R2 R3 advance");

    writeProf({16'h0F0F, 16'hFFF0, 32'hF123_4567}, "R5 write large ftw");
    run(2, "R5 still old");
    update(0, 0, "R9 continuous update");
    run(10, "R2 unsigned wrap");

    writeProf({16'h00AA, 16'h4000, 32'h0003_0001}, "R7 write");
    update(0, 1, "R7 long strobe transfer");
    writeProf({16'h7777, 16'h1111, 32'h0800_0000}, "R7 write during high");
    run(5, "R7 no second transfer");
    ioUpdate = 1'b0;
    run(3, "R7 released, params unchanged");

    setCfg(0, 1, "R11 no write strobe");
    update(0, 0, "R11 auto-clear still off");
    run(3, "R9 continuous");

    setCfg(1, 1, "R11 enable auto-clear");
    writeProf({16'h5555, 16'h2000, 32'h1000_0001}, "R8 write");
    run(2, "R8 before update");
    update(1, 0, "R8 auto-clear dead cycle");
    run(5, "R8 run from zero");
    writeProf({16'h0001, 16'h0000, 32'hC000_0000}, "R8 write 2");
    update(1, 0, "R8 second auto-clear");
    run(4, "R8 run 2");

    setCfg(1, 0, "R11 disable auto-clear");
    writeProf({16'h2222, 16'h8000, 32'h0000_FFFF}, "R9 write");
    update(0, 0, "R9 continuous after disable");
    run(4, "R9 run");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule